// File: doc/BRIEF.md
# Quasi-Bidirectional Port Pin Controller

This block controls a group of pins that serve as input or output without any direction register. Each pin has an output latch bit. A latch bit of 0 turns on a strong low driver on that pin. A latch bit of 1 leaves only a weak pull-up, so an outside source can pull the pin low and the pin can be read as an input. When software writes a 1 to a bit, the block adds a strong pull-up on that pin to give it a fast rising edge. This strong pull-up stays on only until the next falling edge of the serial clock, and then the pin falls back to the weak pull-up.

The bus controller supplies a write strobe with the new data byte, the serial clock as sampled in the system clock domain, and a read strobe. The block returns the pin levels as they stood when the read strobe came. Pin levels pass through a synchroniser before they are used, and any bit whose latch is 0 reads as low.

A small state machine times the strong pull-up. It has two states. `QB_HOLD` means no strong pull-up is active. `QB_BOOST` means the pull-up mask taken at the last write is being driven. The state machine makes these transitions:

- `arm`: from `QB_HOLD` to `QB_BOOST`, on a write that carries at least one 1 bit.
- `rearm`: from `QB_BOOST` back to `QB_BOOST`, on a write that carries at least one 1 bit. This reloads the mask.
- `quench`: from `QB_BOOST` to `QB_HOLD`, on a falling edge of the serial clock with no write in the same cycle.
- `clear`: from `QB_BOOST` to `QB_HOLD`, on a write of all zeros.

Every other case holds the current state.

Top module: `qb_port_ctrl`

## Requirements
- R1: After reset, every latch bit is 1. So `drive_low` is 0x00, `boost_up` is 0x00 and `rd_data` is 0xFF.
- R2: A cycle with `wr_pulse` high loads `wr_data` into the latch. From the next clock edge on, `drive_low` equals the bitwise inverse of `wr_data`.
- R3: From the clock edge that takes a write, `boost_up` equals `wr_data`. This includes bits that were already 1 and are written 1 again.
- R4: A bit written 0 never has its `boost_up` bit set, whatever its previous value was.
- R5: `boost_up` stays set while `scl` stays high, low or rising. It goes to 0x00 at the clock edge that first sees `scl` low after seeing it high, if no write falls in that cycle.
- R6: When a write and a falling edge of `scl` fall in the same cycle, the write wins. `boost_up` takes the new `wr_data` and is cleared only by a later falling edge.
- R7: Without a write, the latch holds its value. Activity on `scl` or `rd_pulse` never changes `drive_low`.
- R8: A cycle with `rd_pulse` high loads into `rd_data` the `pin_in` value that was present two clock edges earlier. `rd_data` holds between reads.
- R9: In a read, every bit whose latch is 0 reads as 0, whatever the level of `pin_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_pulse | input | 1 | Write strobe from the bus controller |
| wr_data | input | 8 | New latch value |
| scl | input | 1 | Serial clock, already sampled in the clk domain |
| rd_pulse | input | 1 | Read strobe from the bus controller |
| pin_in | input | 8 | Raw pin levels (asynchronous) |
| drive_low | output | 8 | Per-bit enable of the strong low driver |
| boost_up | output | 8 | Per-bit enable of the short strong pull-up |
| rd_data | output | 8 | Pin levels captured at the last read |

## Verification
A write strobe and a falling edge of the serial clock can land in the same clock cycle. The first would load a new pull-up mask and the second would end the pulse. The bench first arms the pull-up with one pattern and then, while `scl` is high, drives `scl` low in the same cycle as a write of a different pattern. It judges the result by requiring `boost_up` to show the new pattern after that edge, and to clear only at the next separate falling edge. A read strobe that arrives one cycle after a pin change is also checked, to confirm that the value returned is the value from before the change.

// File: rtl/qb_pkg.sv
package qb_pkg;
    typedef enum logic [0:0] {
        QB_HOLD  = 1'b0,
        QB_BOOST = 1'b1
    } qb_state_e;
endpackage

// File: rtl/qb_sync.sv
module qb_sync #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [DEPTH-1:0][WIDTH-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '1;
        end else begin
            chain[0] <= din;
            for (int i = 1; i < DEPTH; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign dout = chain[DEPTH-1];
endmodule

// File: rtl/qb_boost_fsm.sv
module qb_boost_fsm
    import qb_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_pulse,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             scl,
    output logic [WIDTH-1:0] boost_up
);
    qb_state_e        state, state_nx;
    logic [WIDTH-1:0] mask;
    logic             scl_q;
    logic             scl_fall;

    assign scl_fall = scl_q & ~scl;

    always_comb begin
        state_nx = state;
        unique case (state)
            QB_HOLD: begin
                if (wr_pulse && (|wr_data)) state_nx = QB_BOOST;          // arm
            end
            QB_BOOST: begin
                if (wr_pulse)      state_nx = (|wr_data) ? QB_BOOST : QB_HOLD; // rearm / clear
                else if (scl_fall) state_nx = QB_HOLD;                         // quench
            end
            default: state_nx = QB_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= QB_HOLD;
            mask  <= '0;
            scl_q <= 1'b1;
        end else begin
            state <= state_nx;
            scl_q <= scl;
            if (wr_pulse) mask <= wr_data;
        end
    end

    always_comb begin
        unique case (state)
            QB_BOOST: boost_up = mask;
            default:  boost_up = '0;
        endcase
    end

    // R3
    boost_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |=> boost_up == $past(wr_data));

    // R5
    boost_quench_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_q && !scl && !wr_pulse) |=> boost_up == '0);
endmodule

// File: rtl/qb_port_ctrl.sv
module qb_port_ctrl #(
    parameter int WIDTH      = 8,
    parameter int SYNC_DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_pulse,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             scl,
    input  logic             rd_pulse,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] drive_low,
    output logic [WIDTH-1:0] boost_up,
    output logic [WIDTH-1:0] rd_data
);
    logic [WIDTH-1:0] latch;
    logic [WIDTH-1:0] pin_sync;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch <= '1;
        end else if (wr_pulse) begin
            latch <= wr_data;
        end
    end

    assign drive_low = ~latch;

    qb_sync #(.WIDTH(WIDTH), .DEPTH(SYNC_DEPTH)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_in),
        .dout  (pin_sync)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '1;
        end else if (rd_pulse) begin
            rd_data <= pin_sync & latch;
        end
    end

    qb_boost_fsm #(.WIDTH(WIDTH)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_pulse (wr_pulse),
        .wr_data  (wr_data),
        .scl      (scl),
        .boost_up (boost_up)
    );

    // R4
    no_fight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (boost_up & drive_low) == '0);

    // R7
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_pulse |=> $stable(drive_low));

    // R9
    read_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_pulse |=> (rd_data & drive_low) == '0);
endmodule

// File: tb/sim_qb_port_ctrl.sv
module sim_qb_port_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_pulse = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       scl = 1'b1;
    logic       rd_pulse = 1'b0;
    logic [7:0] pin_in = 8'hFF;
    logic [7:0] drive_low, boost_up, rd_data;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    qb_port_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .wr_pulse(wr_pulse), .wr_data(wr_data),
        .scl(scl), .rd_pulse(rd_pulse), .pin_in(pin_in),
        .drive_low(drive_low), .boost_up(boost_up), .rd_data(rd_data)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_write(input logic [7:0] d);
        wr_pulse = 1'b1; wr_data = d;
        tick();
        wr_pulse = 1'b0;
    endtask

    task automatic do_read();
        rd_pulse = 1'b1;
        tick();
        rd_pulse = 1'b0;
    endtask

    task automatic scl_fall();
        scl = 1'b1; tick();
        scl = 1'b0; tick();
        scl = 1'b1;
    endtask

    task automatic t_reset();
        check("R1 drive_low", drive_low, 8'h00);
        check("R1 boost_up", boost_up, 8'h00);
        check("R1 rd_data", rd_data, 8'hFF);
    endtask

    task automatic t_write_boost();
        do_write(8'hA5);
        check("R2 drive_low", drive_low, 8'h5A);
        check("R3 boost_up", boost_up, 8'hA5);
        repeat (3) tick();
        check("R5 boost held while scl high", boost_up, 8'hA5);
        scl = 1'b0; tick();
        check("R5 boost cleared on scl fall", boost_up, 8'h00);
        check("R7 latch after scl", drive_low, 8'h5A);
        scl = 1'b1; tick();
        check("R5 no boost on scl rise", boost_up, 8'h00);
    endtask

    task automatic t_rewrite();
        do_write(8'hFF);
        check("R3 rewrite of ones boosts", boost_up, 8'hFF);
        do_write(8'h0F);
        check("R4 bits written 0 not boosted", boost_up, 8'h0F);
        check("R2 drive_low", drive_low, 8'hF0);
        scl_fall();
        check("R5 cleared", boost_up, 8'h00);
        do_write(8'h00);
        check("R4 all-zero write gives no boost", boost_up, 8'h00);
        check("R2 all low", drive_low, 8'hFF);
    endtask

    task automatic t_collide();
        scl = 1'b1; tick();
        do_write(8'h3C);
        check("R3 boost armed", boost_up, 8'h3C);
        scl = 1'b0; wr_pulse = 1'b1; wr_data = 8'hC3;
        tick();
        wr_pulse = 1'b0;
        check("R6 write wins over scl fall", boost_up, 8'hC3);
        check("R6 latch", drive_low, 8'h3C);
        scl = 1'b1; tick();
        check("R6 boost kept until next fall", boost_up, 8'hC3);
        scl = 1'b0; tick();
        check("R6 later fall clears", boost_up, 8'h00);
        scl = 1'b1; tick();
    endtask

    task automatic t_read();
        do_write(8'hFF);
        scl_fall();
        pin_in = 8'h96;
        repeat (3) tick();
        do_read();
        check("R8 read pins", rd_data, 8'h96);
        check("R7 read leaves latch", drive_low, 8'h00);
        pin_in = 8'h00;
        repeat (4) tick();
        check("R8 hold between reads", rd_data, 8'h96);
        do_read();
        check("R8 read zeros", rd_data, 8'h00);
        pin_in = 8'h5A;
        tick();
        do_read();
        check("R8 two-stage delay", rd_data, 8'h00);
        do_write(8'h0F);
        pin_in = 8'hFF;
        repeat (3) tick();
        do_read();
        check("R9 low latch reads 0", rd_data, 8'h0F);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_write_boost();
        t_rewrite();
        t_collide();
        t_read();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule